// File: doc/BRIEF.md
# GPIO Pad Controller

This block turns a small set of per-pin configuration bits into the control lines of a bank of general-purpose I/O pads. Each pin is set up as either an analog pin or a digital pin. A digital pin either drives both rails (push-pull) or only pulls the pad low (open-drain). From these settings and an output latch, the block derives three enables for each pad: drive high, drive low and weak pull-up. It also returns the level sampled at the pad to a port read bus.

Software-side configuration arrives on a plain synchronous write port. The port has a write strobe, a 2-bit register select and a data bus. Bit n of a per-pin register controls pin n. Every output is a plain level signal. There is no streaming data path and therefore no valid/ready handshake: a write is accepted on any clock edge where the strobe is high.

The pad level is an asynchronous input. It passes through a two-flop synchronizer before it appears on the read bus. A digital pin reads back the level on the pad, not the value in its latch.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every pin is digital and open-drain, its latch holds 1 and the global pull-up disable is 0. As a result, no driver is enabled and every weak pull-up is on.
- R2: A write is taken on a rising edge with `cfg_we` high. The select codes are: 0 = digital-enable (1 = digital, 0 = analog), 1 = push-pull (1 = push-pull, 0 = open-drain), 2 = global control (bit 0 = weak pull-up disable), 3 = output latch. Data bits at or above NUM_PINS are ignored, and so are bits 1 and up of the global control write.
- R3: A digital push-pull pin drives high when its latch is 1 and drives low when its latch is 0.
- R4: A digital open-drain pin never drives high. It drives low when its latch is 0 and leaves the pad floating when its latch is 1.
- R5: An analog pin has both drivers and its pull-up off. Its read-back bit is 0 from the first cycle after the write that selects analog mode.
- R6: A pin's pull-up is on only when the pin is digital, its low driver is off and the global disable bit is 0. Setting the global disable bit turns off every pull-up.
- R7: On a pin that stays digital, the read-back bit equals the pad level sampled two rising edges earlier, whatever the latch holds.
- R8: No pin ever has its high and low drivers enabled at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 digital-enable, 1 push-pull, 2 global, 3 latch) |
| cfg_wdata | input | DATA_W | Write data, bit n for pin n |
| pad_in | input | NUM_PINS | Sampled pad levels |
| drive_hi | output | NUM_PINS | High-side driver enables |
| drive_lo | output | NUM_PINS | Low-side driver enables |
| pull_en | output | NUM_PINS | Weak pull-up enables |
| port_rd | output | NUM_PINS | Synchronized read-back value |

## Verification
The bench builds the block with NUM_PINS = 6 and DATA_W = 8. With those values the data bus carries bits above the last pin, so the rule that such bits are ignored can be exercised. SYNC_STAGES stays at 2, so the two-edge read-back latency can be checked edge by edge, and the matching timing assertion is active. A behavioural pad in the bench resolves the drivers, the pull-ups and an external source, so every read-back the bench expects follows from the pin configuration.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_DIGEN    = 2'd0,
    SEL_PUSHPULL = 2'd1,
    SEL_GLOBAL   = 2'd2,
    SEL_LATCH    = 2'd3
  } cfg_sel_e;

  localparam int GLB_PU_OFF_BIT = 0;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [SEL_W-1:0]    sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] dig_en,
  output logic [NUM_PINS-1:0] push_pull,
  output logic [NUM_PINS-1:0] latch,
  output logic                pu_off
);

  logic [NUM_PINS-1:0] pin_bits;
  assign pin_bits = wdata[NUM_PINS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_en    <= '1;
      push_pull <= '0;
      latch     <= '1;
      pu_off    <= 1'b0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_DIGEN:    dig_en    <= pin_bits;
        SEL_PUSHPULL: push_pull <= pin_bits;
        SEL_GLOBAL:   pu_off    <= wdata[GLB_PU_OFF_BIT];
        SEL_LATCH:    latch     <= pin_bits;
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic dig,
  input  logic pp,
  input  logic lat,
  input  logic pu_off,
  output logic hi,
  output logic lo,
  output logic pu
);

  logic low_req;

  always_comb begin
    low_req = dig & ~lat;
    hi      = dig & pp & lat;
    lo      = low_req;
    pu      = dig & ~low_req & ~pu_off;
  end

endmodule

// File: rtl/gpio_rd_sync.sv
module gpio_rd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] drive_hi,
  output logic [NUM_PINS-1:0] drive_lo,
  output logic [NUM_PINS-1:0] pull_en,
  output logic [NUM_PINS-1:0] port_rd
);

  logic [NUM_PINS-1:0] dig_en, push_pull, latch;
  logic                pu_off;
  logic [NUM_PINS-1:0] rx_gated, rx_sync;

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .dig_en(dig_en), .push_pull(push_pull), .latch(latch), .pu_off(pu_off)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_cell u_cell (
      .dig(dig_en[p]), .pp(push_pull[p]), .lat(latch[p]), .pu_off(pu_off),
      .hi(drive_hi[p]), .lo(drive_lo[p]), .pu(pull_en[p])
    );
  end

  // Digital receiver disabled on analog pins before and after the synchronizer.
  assign rx_gated = pad_in & dig_en;

  gpio_rd_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_gated), .q(rx_sync)
  );

  assign port_rd = rx_sync & dig_en;

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_hi & drive_lo) == '0); // R8
  AST_ANALOG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((drive_hi | drive_lo | pull_en | port_rd) & ~dig_en) == '0); // R5
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_hi & ~push_pull) == '0); // R4
  AST_PU_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pu_off |-> (pull_en == '0)); // R6
  AST_PU_NOT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & drive_lo) == '0); // R6

  if (SYNC_STAGES == 2) begin : g_lat_chk
    AST_RD_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && (dig_en == $past(dig_en)) &&
       ($past(dig_en) == $past(dig_en, 2)))
      |-> (port_rd == ($past(pad_in, 2) & dig_en))); // R7
  end

endmodule

// File: tb/gpio_pad_ctrl_bench.sv
module gpio_pad_ctrl_bench;

  localparam int N   = 6;
  localparam int DW  = 8;
  localparam time TP = 8ns;

  typedef struct {
    string      req;
    logic [N-1:0] hi, lo, pu, rd;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [N-1:0] pad_in;
  logic [N-1:0] drive_hi, drive_lo, pull_en, port_rd;

  logic [N-1:0] ext_en = '0, ext_val = '0;
  logic [N-1:0] m_dig = '1, m_pp = '0, m_lat = '1;
  logic         m_puoff = 1'b0;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(TP/2) clk = ~clk;

  gpio_pad_ctrl #(.NUM_PINS(N), .DATA_W(DW), .SYNC_STAGES(2)) u_gpio_pad_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pad_in(pad_in), .drive_hi(drive_hi),
    .drive_lo(drive_lo), .pull_en(pull_en), .port_rd(port_rd)
  );

  // Behavioural pad: own drivers win, then external source, then pull-up.
  always_comb begin
    for (int i = 0; i < N; i++)
      pad_in[i] = drive_hi[i] ? 1'b1 : drive_lo[i] ? 1'b0 :
                  ext_en[i] ? ext_val[i] : pull_en[i];
  end

  function automatic void model(output logic [N-1:0] hi, lo, pu, pad);
    for (int i = 0; i < N; i++) begin
      hi[i]  = m_dig[i] & m_pp[i] & m_lat[i];
      lo[i]  = m_dig[i] & ~m_lat[i];
      pu[i]  = m_dig[i] & ~lo[i] & ~m_puoff;
      pad[i] = hi[i] ? 1'b1 : lo[i] ? 1'b0 : ext_en[i] ? ext_val[i] : pu[i];
    end
  endfunction

  task automatic cmp(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard at each falling edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      cmp(it.req, "drive_hi", drive_hi, it.hi);
      cmp(it.req, "drive_lo", drive_lo, it.lo);
      cmp(it.req, "pull_en",  pull_en,  it.pu);
      cmp(it.req, "port_rd",  port_rd,  it.rd);
      cmp("R8", "contention", drive_hi & drive_lo, '0);
    end
  end

  task automatic push(string req, logic [N-1:0] rd);
    exp_t it;
    logic [N-1:0] pad;
    it.req = req;
    model(it.hi, it.lo, it.pu, pad);
    it.rd = rd;
    q.push_back(it);
    while (q.size() != 0) @(negedge clk);
    #1;
  endtask

  task automatic settle_check(string req);
    logic [N-1:0] hi, lo, pu, pad;
    repeat (3) @(posedge clk);
    #1;
    model(hi, lo, pu, pad);
    push(req, pad & m_dig);
  endtask

  task automatic wr(logic [1:0] sel, logic [DW-1:0] data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_dig   = data[N-1:0];
      2'd1: m_pp    = data[N-1:0];
      2'd2: m_puoff = data[0];
      default: m_lat = data[N-1:0];
    endcase
  endtask

  initial begin
    #(TP * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] prev;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, pads float high on pull-ups
    settle_check("R1");

    // R2: bits above the pin count and upper global bits ignored
    wr(2'd2, 8'hFE);
    settle_check("R2");
    wr(2'd3, 8'hC0 | 8'h15);
    settle_check("R2");

    // R4: open-drain latch pattern
    wr(2'd3, 8'h2A);
    settle_check("R4");

    // R3: push-pull on all pins, two latch patterns
    wr(2'd1, 8'h3F);
    settle_check("R3");
    wr(2'd3, 8'h15);
    settle_check("R3");

    // R6: global pull-up disable; mixed modes
    wr(2'd1, 8'h0F);
    wr(2'd3, 8'h3C);
    settle_check("R6");
    wr(2'd2, 8'h01);
    settle_check("R6");
    wr(2'd2, 8'h00);
    settle_check("R6");

    // R5: analog pins with an external source driving high
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h3F);
    ext_en = '1; ext_val = '1;
    settle_check("R5");
    prev = port_rd;
    wr(2'd0, 8'h3E);
    push("R5", prev & 6'h3E);   // masked the cycle after the write
    wr(2'd0, 8'h0C);
    settle_check("R5");

    // R7: read-back latency and independence from the latch
    wr(2'd0, 8'h3F);
    ext_val = 6'h2A;
    settle_check("R7");
    prev = port_rd;
    ext_val = 6'h15;
    push("R7", prev);            // after first edge: old value
    @(posedge clk); #1;
    push("R7", 6'h15);           // after second edge: new value
    ext_val = 6'h00;             // latch is 1 but pad is low
    settle_check("R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule